// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank State Tracker

This block watches the command pins of a synchronous DRAM interface on every rising clock edge and turns them into one-hot command strobes. It combines chip-select, the three strobes (row, column, write), the present clock-enable and the clock-enable sampled at the previous edge, the bank address and the auto-precharge address bit. From these it works out the device mode: normal, power down, clock suspend or self refresh.

For each bank it keeps an open/closed flag and the row that is open, plus a pending auto-precharge mark that a per-bank burst-done input resolves. Commands that the current bank state does not allow are refused: the illegal flag rises for one cycle and no state changes. A memory controller model or a protocol monitor uses the block to learn which commands were accepted and which rows are open.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: A command is accepted only when the mode is normal, the clock-enable sampled at the previous edge was high and cs_n is low. The pins {ras_n,cas_n,we_n} decode as: 011 activate (strobe bit 0), 101 read (bit 1), 100 write (bit 2), 010 precharge (bit 3 for one bank, bit 4 for all banks), 000 mode-register set (bit 5), 001 refresh (bit 6 with cke high, bit 7 self-refresh entry with cke low). 111 and 110 give no strobe. At most one strobe bit is high.
- R2: With cs_n high no strobe rises and no bank state changes from the command pins. Burst-done still closes a bank that has a pending auto-precharge.
- R3: An accepted read or write drives auto_pre equal to addr bit 10 in the same output cycle as its strobe. auto_pre is low in every other cycle.
- R4: An accepted precharge with addr bit 10 high closes all banks. With bit 10 low it closes only the bank on the bank input.
- R5: Refresh with cke high leaves the mode normal. Self-refresh entry sets dev_mode to 3. Any edge with cke high while in self refresh returns the mode to 0.
- R6: In normal mode, a previous cke high, cke now low, and a deselect or no-operation give clock suspend (dev_mode 2) if burst_active is high, or power down (dev_mode 1) if it is low. A cke high edge returns either mode to 0. No command is accepted while the mode is not 0.
- R7: Activate is legal only to a closed bank. Read and write are legal only to an open bank. Mode-register set, refresh and self-refresh entry are legal only when every bank is closed. An illegal accepted command raises illegal for one cycle, gives no strobe and changes no state.
- R8: An accepted activate opens the bank and records the 12-bit row from addr on open_rows at slice bank*12.
- R9: A read or write with bit 10 high marks the bank pending. Burst-done for a pending bank closes it. Burst-done for a bank without a pending mark is ignored. A legal command to the same bank in the same cycle takes precedence over burst-done.
- R10: All outputs are registered and show the effect of an edge's inputs after that edge. Reset clears the strobes, auto_pre and illegal, sets the mode to 0, closes all banks and zeroes the rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| cke | input | 1 | Clock enable |
| bank | input | 2 | Bank address |
| addr | input | 12 | Row address; bit 10 selects auto/all precharge |
| burst_active | input | 1 | A data burst is in progress |
| burst_done | input | 4 | Per-bank end of burst |
| cmd_strb | output | 8 | One-hot accepted-command strobes |
| cmd_bank | output | 2 | Bank sampled at the edge |
| auto_pre | output | 1 | Read/write requested auto-precharge |
| illegal | output | 1 | Command refused by bank state |
| dev_mode | output | 2 | 0 normal, 1 power down, 2 clock suspend, 3 self refresh |
| bank_open | output | 4 | Per-bank open flag |
| open_rows | output | 48 | Open row per bank, 12 bits each |

## Verification
Two functions can act on one bank in the same cycle: an auto-precharge completing through burst_done, and a new command to that bank. The bench provokes this by sending a read to a pending bank with burst_done for that bank held high. It checks that the bank stays open and that the pending mark then follows the new read's bit 10. A second collision is a cke falling edge at the same time as a quiet command while a burst runs. The bench judges it by whether dev_mode shows suspend rather than power down. Sweeps of every pin combination cover both collisions again from many bank states, with a bench reference model working out the expected outputs.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;
   typedef enum logic [1:0] {
      MODE_RUN  = 2'd0,
      MODE_PDN  = 2'd1,
      MODE_SUSP = 2'd2,
      MODE_SREF = 2'd3
   } dev_mode_e;

   localparam int NCMD   = 8;
   localparam int C_ACT  = 0;
   localparam int C_RD   = 1;
   localparam int C_WR   = 2;
   localparam int C_PRE  = 3;
   localparam int C_PALL = 4;
   localparam int C_MRS  = 5;
   localparam int C_REF  = 6;
   localparam int C_SREF = 7;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
   import sdram_trk_pkg::*;
#(
   parameter int NBANK = 4,
   parameter int BA_W  = 2
) (
   input  logic                 cs_n,
   input  logic                 ras_n,
   input  logic                 cas_n,
   input  logic                 we_n,
   input  logic                 cke,
   input  logic                 cke_q,
   input  logic                 run,
   input  logic [BA_W-1:0]      bank,
   input  logic                 ap,
   input  logic [NBANK-1:0]     open_vec,
   output logic [NCMD-1:0]      strb,
   output logic                 illegal,
   output logic                 quiet
);
   logic [2:0]      pins;
   logic [NCMD-1:0] raw;
   logic            accept;
   logic            sel_open;
   logic            all_idle;
   logic            legal;

   assign pins     = {ras_n, cas_n, we_n};
   assign accept   = run & cke_q & ~cs_n;
   assign sel_open = open_vec[bank];
   assign all_idle = ~|open_vec;
   assign quiet    = cs_n | (pins == 3'b111);

   always_comb begin
      raw = '0;
      unique case (pins)
         3'b011:  raw[C_ACT] = 1'b1;
         3'b101:  raw[C_RD]  = 1'b1;
         3'b100:  raw[C_WR]  = 1'b1;
         3'b010:  if (ap) raw[C_PALL] = 1'b1; else raw[C_PRE] = 1'b1;
         3'b000:  raw[C_MRS] = 1'b1;
         3'b001:  if (cke) raw[C_REF] = 1'b1; else raw[C_SREF] = 1'b1;
         default: raw = '0;
      endcase
   end

   always_comb begin
      legal = 1'b1;
      if (raw[C_ACT])
         legal = ~sel_open;
      else if (raw[C_RD] | raw[C_WR])
         legal = sel_open;
      else if (raw[C_MRS] | raw[C_REF] | raw[C_SREF])
         legal = all_idle;
   end

   assign strb    = (accept && legal) ? raw : '0;
   assign illegal = accept & (|raw) & ~legal;
endmodule

// File: rtl/sdram_mode_fsm.sv
module sdram_mode_fsm
   import sdram_trk_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cke,
   input  logic      quiet,
   input  logic      burst_active,
   input  logic      sref_go,
   output dev_mode_e mode,
   output logic      cke_q
);
   dev_mode_e mode_nx;

   always_comb begin
      mode_nx = mode;
      case (mode)
         MODE_RUN: begin
            if (sref_go)
               mode_nx = MODE_SREF;
            else if (cke_q && !cke && quiet)
               mode_nx = burst_active ? MODE_SUSP : MODE_PDN;
         end
         default: begin
            if (cke)
               mode_nx = MODE_RUN;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode  <= MODE_RUN;
         cke_q <= 1'b1;
      end else begin
         mode  <= mode_nx;
         cke_q <= cke;
      end
   end
endmodule

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot #(
   parameter int ROW_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_hit,
   input  logic             pre_hit,
   input  logic             rw_hit,
   input  logic             rw_ap,
   input  logic             done,
   input  logic [ROW_W-1:0] row_in,
   output logic             is_open,
   output logic [ROW_W-1:0] row
);
   logic pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         is_open <= 1'b0;
         pend    <= 1'b0;
         row     <= '0;
      end else if (act_hit) begin
         is_open <= 1'b1;
         pend    <= 1'b0;
         row     <= row_in;
      end else if (pre_hit) begin
         is_open <= 1'b0;
         pend    <= 1'b0;
      end else if (rw_hit) begin
         pend    <= rw_ap;
      end else if (done && pend) begin
         is_open <= 1'b0;
         pend    <= 1'b0;
      end
   end
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
   import sdram_trk_pkg::*;
#(
   parameter int NBANK  = 4,
   parameter int ROW_W  = 12,
   parameter int AP_BIT = 10,
   localparam int BA_W  = $clog2(NBANK)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cs_n,
   input  logic                   ras_n,
   input  logic                   cas_n,
   input  logic                   we_n,
   input  logic                   cke,
   input  logic [BA_W-1:0]        bank,
   input  logic [ROW_W-1:0]       addr,
   input  logic                   burst_active,
   input  logic [NBANK-1:0]       burst_done,
   output logic [NCMD-1:0]        cmd_strb,
   output logic [BA_W-1:0]        cmd_bank,
   output logic                   auto_pre,
   output logic                   illegal,
   output logic [1:0]             dev_mode,
   output logic [NBANK-1:0]       bank_open,
   output logic [NBANK*ROW_W-1:0] open_rows
);
   generate
      if (NBANK < 2 || NBANK != (1 << BA_W)) begin : g_bad_nbank
         $error("NBANK must be a power of two of at least 2");
      end
      if (AP_BIT >= ROW_W) begin : g_bad_ap
         $error("AP_BIT must lie inside the address");
      end
   endgenerate

   dev_mode_e       mode;
   logic            cke_q;
   logic [NCMD-1:0] strb_d;
   logic            ill_d;
   logic            quiet;

   sdram_cmd_decode #(.NBANK(NBANK), .BA_W(BA_W)) u_dec (
      .cs_n     (cs_n),
      .ras_n    (ras_n),
      .cas_n    (cas_n),
      .we_n     (we_n),
      .cke      (cke),
      .cke_q    (cke_q),
      .run      (mode == MODE_RUN),
      .bank     (bank),
      .ap       (addr[AP_BIT]),
      .open_vec (bank_open),
      .strb     (strb_d),
      .illegal  (ill_d),
      .quiet    (quiet)
   );

   sdram_mode_fsm u_mode (
      .clk          (clk),
      .rst_n        (rst_n),
      .cke          (cke),
      .quiet        (quiet),
      .burst_active (burst_active),
      .sref_go      (strb_d[C_SREF]),
      .mode         (mode),
      .cke_q        (cke_q)
   );

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic hit;
      assign hit = (bank == BA_W'(b));
      sdram_bank_slot #(.ROW_W(ROW_W)) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .act_hit (strb_d[C_ACT] & hit),
         .pre_hit (strb_d[C_PALL] | (strb_d[C_PRE] & hit)),
         .rw_hit  ((strb_d[C_RD] | strb_d[C_WR]) & hit),
         .rw_ap   (addr[AP_BIT]),
         .done    (burst_done[b]),
         .row_in  (addr),
         .is_open (bank_open[b]),
         .row     (open_rows[b*ROW_W +: ROW_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_strb <= '0;
         cmd_bank <= '0;
         auto_pre <= 1'b0;
         illegal  <= 1'b0;
      end else begin
         cmd_strb <= strb_d;
         cmd_bank <= bank;
         auto_pre <= (strb_d[C_RD] | strb_d[C_WR]) & addr[AP_BIT];
         illegal  <= ill_d;
      end
   end

   assign dev_mode = mode;
endmodule

// File: rtl/sdram_trk_chk.sv
module sdram_trk_chk
   import sdram_trk_pkg::*;
#(
   parameter int NBANK = 4,
   parameter int ROW_W = 12,
   parameter int BA_W  = 2
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [ROW_W-1:0]       addr,
   input logic [NCMD-1:0]        cmd_strb,
   input logic [BA_W-1:0]        cmd_bank,
   input logic                   auto_pre,
   input logic                   illegal,
   input logic [1:0]             dev_mode,
   input logic [NBANK-1:0]       bank_open,
   input logic [NBANK*ROW_W-1:0] open_rows
);
   assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cmd_strb));

   assert_ap_rw_R3: assert property (@(posedge clk) disable iff (!rst_n)
      auto_pre |-> (cmd_strb[C_RD] | cmd_strb[C_WR]));

   assert_pall_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_strb[C_PALL] |-> (bank_open == '0));

   assert_sref_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_strb[C_SREF] |-> (dev_mode == 2'd3));

   assert_asleep_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_mode != 2'd0 && $past(dev_mode) != 2'd0) |-> (cmd_strb == '0));

   assert_illegal_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (cmd_strb == '0));

   assert_rw_to_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_strb[C_RD] | cmd_strb[C_WR]) |-> bank_open[cmd_bank]);

   assert_act_row_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_strb[C_ACT] |-> (bank_open[cmd_bank] &&
         open_rows[int'(cmd_bank)*ROW_W +: ROW_W] == $past(addr)));
endmodule

bind sdram_cmd_tracker sdram_trk_chk #(.NBANK(NBANK), .ROW_W(ROW_W), .BA_W(BA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .addr      (addr),
   .cmd_strb  (cmd_strb),
   .cmd_bank  (cmd_bank),
   .auto_pre  (auto_pre),
   .illegal   (illegal),
   .dev_mode  (dev_mode),
   .bank_open (bank_open),
   .open_rows (open_rows)
);

// File: tb/tb_sdram_cmd_tracker.sv
module tb_sdram_cmd_tracker;
   localparam int NB = 4;
   localparam int RW = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
   logic [1:0] bank = '0;
   logic [RW-1:0] addr = '0;
   logic burst_active = 1'b0;
   logic [NB-1:0] burst_done = '0;
   logic [7:0] cmd_strb;
   logic [1:0] cmd_bank;
   logic auto_pre, illegal;
   logic [1:0] dev_mode;
   logic [NB-1:0] bank_open;
   logic [NB*RW-1:0] open_rows;

   int n_vec = 0;
   int n_bad = 0;

   // reference state built from the requirements
   logic [NB-1:0]    m_open = '0;
   logic [NB-1:0]    m_pend = '0;
   logic [NB*RW-1:0] m_rows = '0;
   logic [1:0]       m_mode = 2'd0;
   logic             m_ckeq = 1'b1;
   logic [7:0]       e_strb = '0;
   logic [1:0]       e_bank = '0;
   logic             e_ap = 1'b0;
   logic             e_ill = 1'b0;

   sdram_cmd_tracker dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .cke(cke), .bank(bank), .addr(addr),
      .burst_active(burst_active), .burst_done(burst_done),
      .cmd_strb(cmd_strb), .cmd_bank(cmd_bank), .auto_pre(auto_pre),
      .illegal(illegal), .dev_mode(dev_mode), .bank_open(bank_open),
      .open_rows(open_rows)
   );

   always #2 clk = ~clk;

   task automatic model_edge();
      logic [2:0] op;
      int k;
      logic acc, ok, a10, quiet;
      logic [1:0] nm;
      op    = {ras_n, cas_n, we_n};
      a10   = addr[10];
      acc   = (m_mode == 2'd0) && m_ckeq && !cs_n;
      quiet = cs_n || (op == 3'b111);
      case (op)
         3'b011:  k = 0;
         3'b101:  k = 1;
         3'b100:  k = 2;
         3'b010:  k = a10 ? 4 : 3;
         3'b000:  k = 5;
         3'b001:  k = cke ? 6 : 7;
         default: k = -1;
      endcase
      if (k == 0)           ok = !m_open[bank];
      else if (k == 1 || k == 2) ok = m_open[bank];
      else if (k >= 5)      ok = (m_open == '0);
      else                  ok = 1'b1;
      e_strb = '0; e_ill = 1'b0; e_ap = 1'b0; e_bank = bank;
      if (acc && k >= 0) begin
         if (ok) begin
            e_strb[k] = 1'b1;
            e_ap = (k == 1 || k == 2) && a10;
         end else e_ill = 1'b1;
      end
      nm = m_mode;
      if (m_mode != 2'd0) begin
         if (cke) nm = 2'd0;
      end else if (e_strb[7]) nm = 2'd3;
      else if (m_ckeq && !cke && quiet) nm = burst_active ? 2'd2 : 2'd1;
      m_mode = nm;
      for (int b = 0; b < NB; b++) begin
         logic hit;
         hit = (bank == 2'(b));
         if (e_strb[0] && hit) begin
            m_open[b] = 1'b1; m_pend[b] = 1'b0; m_rows[b*RW +: RW] = addr;
         end else if (e_strb[4] || (e_strb[3] && hit)) begin
            m_open[b] = 1'b0; m_pend[b] = 1'b0;
         end else if ((e_strb[1] || e_strb[2]) && hit) begin
            m_pend[b] = a10;
         end else if (burst_done[b] && m_pend[b]) begin
            m_open[b] = 1'b0; m_pend[b] = 1'b0;
         end
      end
      m_ckeq = cke;
   endtask

   task automatic compare(string req);
      logic bad;
      bad = 1'b0;
      n_vec++;
      if (cmd_strb !== e_strb) begin
         $display("FAIL R1 %s cmd_strb actual %h expected %h", req, cmd_strb, e_strb); bad = 1'b1;
      end
      if (cmd_bank !== e_bank) begin
         $display("FAIL R10 %s cmd_bank actual %h expected %h", req, cmd_bank, e_bank); bad = 1'b1;
      end
      if (auto_pre !== e_ap) begin
         $display("FAIL R3 %s auto_pre actual %h expected %h", req, auto_pre, e_ap); bad = 1'b1;
      end
      if (illegal !== e_ill) begin
         $display("FAIL R7 %s illegal actual %h expected %h", req, illegal, e_ill); bad = 1'b1;
      end
      if (dev_mode !== m_mode) begin
         $display("FAIL R6 %s dev_mode actual %h expected %h", req, dev_mode, m_mode); bad = 1'b1;
      end
      if (bank_open !== m_open) begin
         $display("FAIL R9 %s bank_open actual %h expected %h", req, bank_open, m_open); bad = 1'b1;
      end
      if (open_rows !== m_rows) begin
         $display("FAIL R8 %s open_rows actual %h expected %h", req, open_rows, m_rows); bad = 1'b1;
      end
      if (bad) n_bad++;
   endtask

   // drives at a falling edge, lets one rising edge pass, checks at the next falling edge
   task automatic apply(input logic c, input logic [2:0] op, input logic ke,
                        input logic [1:0] ba, input logic [RW-1:0] ad,
                        input logic bact, input logic [NB-1:0] bd, input string req);
      cs_n = c; {ras_n, cas_n, we_n} = op; cke = ke; bank = ba; addr = ad;
      burst_active = bact; burst_done = bd;
      model_edge();
      @(posedge clk);
      @(negedge clk);
      compare(req);
   endtask

   task automatic expect_bit(input logic act, input logic exp, input string req);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual %b expected %b", req, act, exp);
      end
   endtask

   localparam logic [2:0] OP_ACT = 3'b011, OP_RD = 3'b101, OP_WR = 3'b100,
                          OP_PRE = 3'b010, OP_MRS = 3'b000, OP_REF = 3'b001,
                          OP_NOP = 3'b111;
   localparam logic [RW-1:0] A10 = 12'h400;

   initial begin
      #(4 * 150000);
      n_bad++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      compare("R10 reset");
      rst_n = 1'b1;
      @(negedge clk);
      compare("R10 after release");

      // R8, R7: open bank 1, activate again is illegal, read to closed bank 2 illegal
      apply(0, OP_ACT, 1, 2'd1, 12'h3a5, 0, 4'h0, "R8 activate");
      expect_bit(bank_open[1], 1'b1, "R8 bank1 open");
      apply(0, OP_ACT, 1, 2'd1, 12'h111, 0, 4'h0, "R7 activate open bank");
      expect_bit(illegal, 1'b1, "R7 illegal on re-activate");
      apply(0, OP_RD, 1, 2'd2, 12'h000, 0, 4'h0, "R7 read closed bank");
      apply(0, OP_MRS, 1, 2'd0, 12'h000, 0, 4'h0, "R7 mode set with bank open");
      // R2: deselect ignores pins
      apply(1, OP_ACT, 1, 2'd3, 12'h0ff, 0, 4'h0, "R2 deselect");
      expect_bit(bank_open[3], 1'b0, "R2 bank3 stays closed");
      // R9, R3: read with auto-precharge, then collision with a new read
      apply(0, OP_RD, 1, 2'd1, A10, 0, 4'h0, "R3 read ap");
      expect_bit(auto_pre, 1'b1, "R3 auto_pre high");
      apply(0, OP_RD, 1, 2'd1, 12'h000, 1, 4'h2, "R9 read beats burst_done");
      expect_bit(bank_open[1], 1'b1, "R9 bank1 kept open");
      apply(0, OP_NOP, 1, 2'd0, 12'h000, 0, 4'h2, "R9 done without pending");
      expect_bit(bank_open[1], 1'b1, "R9 done ignored");
      apply(0, OP_WR, 1, 2'd1, A10, 1, 4'h0, "R3 write ap");
      apply(1, OP_NOP, 1, 2'd0, 12'h000, 0, 4'h2, "R2 R9 done under deselect");
      expect_bit(bank_open[1], 1'b0, "R9 bank1 closed by done");
      // R4: single and all precharge
      apply(0, OP_ACT, 1, 2'd0, 12'h00a, 0, 4'h0, "R8 open bank0");
      apply(0, OP_ACT, 1, 2'd2, 12'h0b0, 0, 4'h0, "R8 open bank2");
      apply(0, OP_PRE, 1, 2'd0, 12'h000, 0, 4'h0, "R4 precharge one");
      expect_bit(bank_open[2], 1'b1, "R4 bank2 untouched");
      apply(0, OP_ACT, 1, 2'd3, 12'hfff, 0, 4'h0, "R8 open bank3");
      apply(0, OP_PRE, 1, 2'd1, A10, 0, 4'h0, "R4 precharge all");
      expect_bit(|bank_open, 1'b0, "R4 all closed");
      // R5: refresh and self refresh
      apply(0, OP_REF, 1, 2'd0, 12'h000, 0, 4'h0, "R5 refresh");
      apply(0, OP_REF, 0, 2'd0, 12'h000, 0, 4'h0, "R5 self refresh entry");
      apply(0, OP_ACT, 0, 2'd0, 12'h000, 0, 4'h0, "R5 ignored in self refresh");
      apply(1, OP_NOP, 1, 2'd0, 12'h000, 0, 4'h0, "R5 exit");
      // R6: suspend versus power down
      apply(0, OP_ACT, 1, 2'd0, 12'h123, 0, 4'h0, "R8 open bank0");
      apply(0, OP_NOP, 0, 2'd0, 12'h000, 1, 4'h0, "R6 suspend entry");
      expect_bit(dev_mode == 2'd2, 1'b1, "R6 in suspend");
      apply(0, OP_ACT, 0, 2'd2, 12'h000, 1, 4'h0, "R6 command ignored");
      apply(1, OP_NOP, 1, 2'd0, 12'h000, 0, 4'h0, "R6 exit suspend");
      apply(1, OP_NOP, 1, 2'd0, 12'h000, 0, 4'h0, "R6 settle");
      apply(1, OP_NOP, 0, 2'd0, 12'h000, 0, 4'h0, "R6 power down entry");
      expect_bit(dev_mode == 2'd1, 1'b1, "R6 in power down");
      apply(1, OP_NOP, 1, 2'd0, 12'h000, 0, 4'h0, "R6 exit power down");

      // sweep over every pin combination from the states it walks through (R1..R10)
      for (int pass = 0; pass < 4; pass++) begin
         for (int i = 0; i < 512; i++) begin
            int j;
            logic [RW-1:0] ad;
            j  = i ^ (pass * 8'h5a);
            ad = RW'((i * 37 + pass * 11) & 12'hfff);
            ad[10] = j[6];
            apply(j[3], j[2:0], (pass == 3) ? 1'b1 : j[7], j[5:4], ad, j[8],
                  (pass[0]) ? 4'(1 << (i % 4)) : 4'h0, "sweep");
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule